// File: doc/BRIEF.md
# Receive Packet Ring Writer

This block takes received Ethernet frames as a byte stream, one byte per cycle, with valid, last and error flags. It writes every accepted frame into a circular, byte-addressed packet ring through a simple write port. It puts a six-byte descriptor in front of each stored frame, so software can walk the ring from one packet to the next without scanning bytes.

The block first leaves room for the descriptor and streams the frame body in behind it. When the last byte arrives it goes back and writes the descriptor: a link to the next packet, the stored length with a wrap flag, the offset of the network-layer header, and the IP protocol number. After that it advances the write pointer that software can see. A mode input picks one of two storage modes. In keep mode the whole frame is stored. In strip mode the 14-byte link header is dropped, so the IP header sits directly after the descriptor.

Software returns space by moving a read-pointer input. A frame that would not fit in front of that pointer is dropped whole and counted. A frame that ends with the error flag is discarded and leaves no trace that software can see.

Top module: `rx_ring_writer`

## Requirements
- R1: Each stored packet starts with a 6-byte descriptor, laid out as follows:
  - bytes 0 and 1: the next-packet address, high byte first;
  - byte 2: wrap flag in bit 7, zeros in bits 6:4, and length bits 11:8 in bits 3:0;
  - byte 3: length bits 7:0, where the length is the number of frame bytes stored after the descriptor;
  - byte 4: the offset from the packet start to the network-layer header;
  - byte 5: the protocol byte.
- R2: In keep mode, every frame byte is stored in order directly after the descriptor, and descriptor byte 4 is 20.
- R3: In strip mode, the first 14 frame bytes are not stored, the following bytes are stored directly after the descriptor, and descriptor byte 4 is 6. The mode is sampled on the first byte of each frame, and later changes to the mode input within that frame have no effect.
- R4: The protocol byte is frame byte 23 when frame bytes 12 and 13 equal 0x08 and 0x00 and the frame holds at least 24 bytes. In every other case it is 0xFF.
- R5: The next-packet address is the packet start plus (6 + length) rounded up to a multiple of 4, modulo the ring size. The write-pointer output takes this value within 8 cycles after the last byte, and only after all six descriptor bytes have been written. The write pointer is always a multiple of 4.
- R6: All ring addresses wrap modulo the ring size. The wrap flag is set when the packet start plus 6 plus the length exceeds the ring size.
- R7: A frame whose last byte carries the error flag changes neither the write pointer nor the drop count. The next frame is stored at the same start address.
- R8: When (6 + length) rounded up to a multiple of 4 is not smaller than the distance from the write pointer to the read pointer, the frame is dropped whole. A distance of 0 counts as the full ring. On a drop the write pointer is unchanged and the drop count rises by exactly one.
- R9: After reset the write pointer and the drop count are zero and no ring write is issued.
- R10: During the 8 cycles after a frame's last byte, the block ignores input bytes. They neither start a frame nor move the write pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_mode | input | 1 | 1 = drop the link header, 0 = keep the whole frame |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 1 | With in_last: the frame is bad and is discarded |
| rd_ptr | input | AW | Ring address up to which software has freed space |
| mem_we | output | 1 | Ring write strobe |
| mem_addr | output | AW | Ring write address |
| mem_data | output | 8 | Ring write byte |
| wr_ptr | output | AW | Start of the next free packet slot, visible to software |
| drop_count | output | DW | Number of frames dropped for lack of space |

## Verification
The bench builds the block with AW = 8, a 256-byte ring, and keeps the 16-bit drop counter. With a ring this small, a single 140-byte frame crosses the ring end, so the wrap flag and the split body can be checked. Moving the read pointer to sit 40 bytes ahead of the write pointer puts the space test at its exact edge: a frame needing 40 bytes is dropped and one needing 36 is taken. The same small ring lets the bench hold a full shadow copy of the ring and compare every descriptor and body byte.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic {ST_RECV, ST_FILL} rxr_state_e;

    localparam int          CW            = 16;       // frame byte/length counter width
    localparam int          DESC_BYTES    = 6;
    localparam int          ETH_HDR_BYTES = 14;
    localparam int          ETYPE_HI_POS  = 12;
    localparam int          ETYPE_LO_POS  = 13;
    localparam int          IP_PROTO_POS  = 23;       // link header + 9
    localparam int          MAX_LEN       = 4095;     // 12-bit length field
    localparam logic [15:0] ETYPE_IPV4    = 16'h0800;
    localparam logic [7:0]  NON_IP_PROTO  = 8'hFF;
endpackage

// File: rtl/rxr_space.sv
// Ring distance, fit test, aligned next-packet address and wrap flag.
module rxr_space
    import rxr_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] rd,
    input  logic [CW-1:0] body,
    output logic [CW-1:0] room,
    output logic [AW-1:0] next,
    output logic          wrap,
    output logic          fits
);
    localparam int RING = 1 << AW;

    logic [AW-1:0] diff;
    logic [CW-1:0] total;
    logic [CW-1:0] aligned;

    always_comb begin
        diff    = rd - base;
        room    = (diff == '0) ? CW'(RING) : CW'(diff);
        total   = CW'(DESC_BYTES) + body;
        aligned = (total + CW'(3)) & {{(CW-2){1'b1}}, 2'b00};
        fits    = (aligned < room) && (body <= CW'(MAX_LEN));
        next    = base + aligned[AW-1:0];
        wrap    = (CW'(base) + total) > CW'(RING);
    end
endmodule

// File: rtl/rxr_hdr.sv
// Selects one descriptor byte by index.
module rxr_hdr #(
    parameter int AW = 13
) (
    input  logic [2:0]    sel,
    input  logic [AW-1:0] next,
    input  logic          wrap,
    input  logic [11:0]   len,
    input  logic [7:0]    off,
    input  logic [7:0]    proto,
    output logic [7:0]    byte_o
);
    logic [15:0] nx;

    always_comb begin
        nx = 16'(next);
        case (sel)
            3'd0:    byte_o = nx[15:8];
            3'd1:    byte_o = nx[7:0];
            3'd2:    byte_o = {wrap, 3'b000, len[11:8]};
            3'd3:    byte_o = len[7:0];
            3'd4:    byte_o = off;
            default: byte_o = proto;
        endcase
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strip_mode,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_err,
    input  logic [AW-1:0] rd_ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    output logic [AW-1:0] wr_ptr,
    output logic [DW-1:0] drop_count
);
    localparam logic [7:0] OFF_STRIP = 8'(DESC_BYTES);
    localparam logic [7:0] OFF_KEEP  = 8'(DESC_BYTES + ETH_HDR_BYTES);

    typedef struct packed {
        rxr_state_e    st;
        logic [AW-1:0] wr_ptr;
        logic [CW-1:0] idx;
        logic [CW-1:0] body;
        logic          strip;
        logic [15:0]   etype;
        logic [7:0]    proto;
        logic          ovf;
        logic [2:0]    fidx;
        logic [DW-1:0] drops;
        logic          we;
        logic [AW-1:0] waddr;
        logic [7:0]    wdata;
    } regs_t;

    regs_t r_q, r_d;

    logic          strip_e, store_e, take_e, ovf_now;
    logic [CW-1:0] slot_k, body_n, room;
    logic [AW-1:0] next_ptr;
    logic          wrap_f, fits_f;
    logic [7:0]    hdr_byte;
    logic          filling;

    // Byte acceptance for the current input beat.
    always_comb begin
        strip_e = (r_q.idx == '0) ? strip_mode : r_q.strip;
        slot_k  = CW'(DESC_BYTES) + r_q.body;
        store_e = !(strip_e && (r_q.idx < CW'(ETH_HDR_BYTES)));
        take_e  = in_valid && (r_q.st == ST_RECV) && store_e && !r_q.ovf && (slot_k < room);
        ovf_now = r_q.ovf || (in_valid && store_e && !take_e);
        body_n  = r_q.body + CW'(take_e);
    end

    rxr_space #(.AW(AW)) u_space (
        .base (r_q.wr_ptr),
        .rd   (rd_ptr),
        .body (body_n),
        .room (room),
        .next (next_ptr),
        .wrap (wrap_f),
        .fits (fits_f)
    );

    rxr_hdr #(.AW(AW)) u_hdr (
        .sel    (r_q.fidx),
        .next   (next_ptr),
        .wrap   (wrap_f),
        .len    (r_q.body[11:0]),
        .off    (r_q.strip ? OFF_STRIP : OFF_KEEP),
        .proto  (r_q.proto),
        .byte_o (hdr_byte)
    );

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        unique case (r_q.st)
            ST_RECV: begin
                if (in_valid) begin
                    r_d.strip = strip_e;
                    r_d.body  = body_n;
                    r_d.ovf   = ovf_now;
                    if (take_e) begin
                        r_d.we    = 1'b1;
                        r_d.waddr = r_q.wr_ptr + slot_k[AW-1:0];
                        r_d.wdata = in_data;
                    end
                    if (r_q.idx == '0)
                        r_d.proto = NON_IP_PROTO;
                    if (r_q.idx == CW'(ETYPE_HI_POS))
                        r_d.etype[15:8] = in_data;
                    if (r_q.idx == CW'(ETYPE_LO_POS))
                        r_d.etype[7:0] = in_data;
                    if ((r_q.idx == CW'(IP_PROTO_POS)) && (r_q.etype == ETYPE_IPV4))
                        r_d.proto = in_data;
                    if (r_q.idx != '1)
                        r_d.idx = r_q.idx + CW'(1);
                    if (in_last) begin
                        r_d.idx = '0;
                        r_d.ovf = 1'b0;
                        if (in_err) begin
                            r_d.body = '0;
                        end else if (!ovf_now && fits_f) begin
                            r_d.st   = ST_FILL;
                            r_d.fidx = '0;
                        end else begin
                            r_d.drops = r_q.drops + DW'(1);
                            r_d.body  = '0;
                        end
                    end
                end
            end
            ST_FILL: begin
                if (r_q.fidx < 3'd6) begin
                    r_d.we    = 1'b1;
                    r_d.waddr = r_q.wr_ptr + AW'(r_q.fidx);
                    r_d.wdata = hdr_byte;
                    r_d.fidx  = r_q.fidx + 3'd1;
                end else begin
                    r_d.wr_ptr = next_ptr;
                    r_d.body   = '0;
                    r_d.st     = ST_RECV;
                end
            end
            default: r_d.st = ST_RECV;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_we     = r_q.we;
    assign mem_addr   = r_q.waddr;
    assign mem_data   = r_q.wdata;
    assign wr_ptr     = r_q.wr_ptr;
    assign drop_count = r_q.drops;
    assign filling    = (r_q.st == ST_FILL);
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int AW = 13,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] wr_ptr,
    input logic [DW-1:0] drops,
    input logic          mem_we,
    input logic          in_valid,
    input logic          in_last,
    input logic          in_err,
    input logic          filling
);
    p_ptr_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr[1:0] == 2'b00);

    p_publish_after_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_ptr) |-> ($past(mem_we) && !mem_we));

    p_err_no_trace_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && in_err && !filling) |=> ($stable(wr_ptr) && $stable(drops)));

    p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drops) |-> (drops == $past(drops) + DW'(1)));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ptr   (wr_ptr),
    .drops    (drop_count),
    .mem_we   (mem_we),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_err   (in_err),
    .filling  (filling)
);

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strip_mode;
    logic          in_valid;
    logic [7:0]    in_data;
    logic          in_last;
    logic          in_err;
    logic [AW-1:0] rd_ptr;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic [AW-1:0] wr_ptr;
    logic [DW-1:0] drop_count;

    logic [7:0] ring [N];
    logic [7:0] fb [300];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rx_ring_writer #(.AW(AW), .DW(DW)) u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .strip_mode(strip_mode), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_err(in_err), .rd_ptr(rd_ptr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .wr_ptr(wr_ptr), .drop_count(drop_count)
    );

    always @(posedge clk) if (mem_we) ring[mem_addr] <= mem_data;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic build(input int len, input int etype, input int proto, input int seed);
        for (int i = 0; i < 300; i++) fb[i] = 8'((i * 13 + seed) & 255);
        fb[12] = 8'(etype >> 8);
        fb[13] = 8'(etype & 255);
        fb[23] = 8'(proto);
        if (len > 300) $display("bench frame too long");
    endtask

    // Drives one frame starting at a negedge; optional mid-frame mode flip and stray byte.
    task automatic drive(input int len, input bit strip, input bit err, input bit flip, input bit stray);
        for (int i = 0; i < len; i++) begin
            strip_mode = (flip && i > 0) ? !strip : strip;
            in_valid = 1'b1;
            in_data  = fb[i];
            in_last  = (i == len - 1);
            in_err   = err && (i == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
        if (stray) begin
            @(negedge clk);
            in_valid = 1'b1; in_last = 1'b1; in_data = 8'hAA;
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic check_pkt(input int start, input int len, input bit strip, input string tag);
        int body, skip, total, al, nxt, wr, prot, bad;
        bit is_ip;
        body  = strip ? ((len > 14) ? len - 14 : 0) : len;
        skip  = strip ? 14 : 0;
        total = 6 + body;
        al    = ((total + 3) / 4) * 4;
        nxt   = (start + al) % N;
        wr    = (start + total > N) ? 1 : 0;
        is_ip = (fb[12] == 8'h08) && (fb[13] == 8'h00);
        prot  = (is_ip && len >= 24) ? int'(fb[23]) : 8'hFF;
        chk(int'(ring[start % N]),       nxt >> 8,                                   {tag, " R1 next hi"});
        chk(int'(ring[(start + 1) % N]), nxt & 255,                                  {tag, " R5 next lo"});
        chk(int'(ring[(start + 2) % N]), (wr << 7) | ((body >> 8) & 15),            {tag, " R6 wrap/len hi"});
        chk(int'(ring[(start + 3) % N]), body & 255,                                 {tag, " R1 len lo"});
        chk(int'(ring[(start + 4) % N]), strip ? 6 : 20,                             {tag, strip ? " R3 offset" : " R2 offset"});
        chk(int'(ring[(start + 5) % N]), prot,                                       {tag, " R4 protocol"});
        bad = 0;
        for (int j = 0; j < body; j++)
            if (ring[(start + 6 + j) % N] != fb[j + skip]) bad++;
        chk(bad, 0, {tag, strip ? " R3 body mismatches" : " R2 body mismatches"});
        chk(int'(wr_ptr), nxt, {tag, " R5 write pointer"});
    endtask

    task automatic t_reset();
        chk(int'(wr_ptr), 0, "R9 reset write pointer");
        chk(int'(drop_count), 0, "R9 reset drop count");
        chk(int'(mem_we), 0, "R9 no write after reset");
    endtask

    task automatic t_keep_ip();
        build(30, 16'h0800, 8'h11, 3);
        rd_ptr = wr_ptr;
        drive(30, 1'b0, 1'b0, 1'b0, 1'b0);
        check_pkt(0, 30, 1'b0, "keep-ip");
    endtask

    task automatic t_strip_ip();
        build(40, 16'h0800, 8'h06, 7);
        rd_ptr = wr_ptr;
        drive(40, 1'b1, 1'b0, 1'b0, 1'b0);
        check_pkt(36, 40, 1'b1, "strip-ip");
    endtask

    task automatic t_non_ip();
        build(25, 16'h0806, 8'h11, 11);
        rd_ptr = wr_ptr;
        drive(25, 1'b0, 1'b0, 1'b0, 1'b0);
        check_pkt(68, 25, 1'b0, "non-ip R4");
    endtask

    task automatic t_short_ip();
        build(20, 16'h0800, 8'h11, 17);
        rd_ptr = wr_ptr;
        drive(20, 1'b0, 1'b0, 1'b0, 1'b0);
        check_pkt(100, 20, 1'b0, "short-ip R4");
    endtask

    task automatic t_error();
        build(10, 16'h0800, 8'h11, 19);
        rd_ptr = wr_ptr;
        drive(10, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(int'(wr_ptr), 128, "R7 error frame leaves write pointer");
        chk(int'(drop_count), 0, "R7 error frame not counted");
    endtask

    task automatic t_wrap();
        build(140, 16'h0800, 8'h01, 23);
        rd_ptr = wr_ptr;
        drive(140, 1'b0, 1'b0, 1'b0, 1'b0);
        check_pkt(128, 140, 1'b0, "wrap R7 same start R6");
    endtask

    task automatic t_space();
        rd_ptr = 8'd60;
        build(34, 16'h0800, 8'h11, 29);
        drive(34, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(int'(wr_ptr), 20, "R8 dropped frame keeps write pointer");
        chk(int'(drop_count), 1, "R8 drop count after one drop");
        build(30, 16'h0800, 8'h11, 31);
        drive(30, 1'b0, 1'b0, 1'b0, 1'b0);
        check_pkt(20, 30, 1'b0, "R8 just-fitting frame");
        chk(int'(drop_count), 1, "R8 drop count unchanged on accept");
    endtask

    task automatic t_mode_latch_and_fill();
        rd_ptr = wr_ptr;
        build(24, 16'h0800, 8'h2F, 37);
        drive(24, 1'b0, 1'b0, 1'b1, 1'b1);
        check_pkt(56, 24, 1'b0, "R3 mode sampled at first byte");
        chk(int'(wr_ptr), 88, "R10 stray byte during fill ignored");
        chk(int'(drop_count), 1, "R10 stray byte not counted");
        rd_ptr = wr_ptr;
        build(30, 16'h0800, 8'h84, 41);
        drive(30, 1'b1, 1'b0, 1'b0, 1'b0);
        check_pkt(88, 30, 1'b1, "R10 frame after stray byte");
    endtask

    initial begin
        for (int i = 0; i < N; i++) ring[i] = 8'hEE;
        rst_n = 1'b0; strip_mode = 1'b0; in_valid = 1'b0; in_data = '0;
        in_last = 1'b0; in_err = 1'b0; rd_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_keep_ip();
        t_strip_ip();
        t_non_ip();
        t_short_ip();
        t_error();
        t_wrap();
        t_space();
        t_mode_latch_and_fill();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule